// File: doc/BRIEF.md
# Lockable Way Replacement Selector

This block chooses which way of an 8-way set-associative cache a read or write miss will overwrite. The cache supports pinning individual lines (per-way lock bits held alongside the tags) and splitting the ways among requesters (a per-requester allowed-way mask). On every miss the surrounding controller presents the lock bits read at the missed index, the requester's allowed-way mask, a flag saying whether the fill should also lock the new line, and a preferred victim from an external replacement-order block. One clock later the selector returns the way to fill and the lock bits to write back at that index.

Two misuse cases are handled in hardware. A lock request that would pin the last way still free for this requester is refused: the fill goes ahead, the line stays unlocked and a refusal flag is raised. A miss that finds every allowed way already pinned cannot honour the locks; the selector then takes the lowest allowed way, unpins it and raises a separate starvation flag. Both flags are sticky, cleared by a write-one pulse, and each has its own interrupt enable feeding one shared interrupt line.

Top module: `repl_way_sel`

## Requirements
- R1: After reset `res_vld`, both error flags and `lock_irq` are 0.
- R2: An allowed-way mask of all zeros is treated as allowing every way.
- R3: When the hint way (`hint_way`, binary way number) is allowed and unlocked, it is the selected way.
- R4: When the hint way is locked or not allowed but some allowed unlocked way exists, the lowest-numbered allowed unlocked way is selected.
- R5: While at least one allowed unlocked way exists, the selected way is never locked and never outside the effective mask.
- R6: A lock request (`lock_req`=1) with two or more allowed unlocked ways sets bit `res_way` of `res_lock_bits` and leaves every other bit equal to `lock_bits_in`.
- R7: A lock request when the selected way is the only allowed unlocked way selects that way normally, returns `res_lock_bits` equal to `lock_bits_in`, and sets the refusal flag; it never sets the starvation flag in the same miss.
- R8: When no allowed way is unlocked, the lowest-numbered allowed way is selected, its bit is cleared in `res_lock_bits` (other bits kept), the starvation flag is set and any lock request is ignored.
- R9: Each flag stays set until a 1 on its clear input; a set and a clear in the same cycle leave the flag set.
- R10: `lock_irq` is 1 exactly when some flag is 1 and its enable input is 1.
- R11: Results appear on the clock edge after the edge that samples `miss_vld`=1; `res_vld` is high for that one cycle, and without a miss `res_way`, `res_lock_bits` and the flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_vld | input | 1 | A miss is presented this cycle |
| lock_bits_in | input | 8 | Lock bits read at the missed index, bit i = way i |
| part_mask | input | 8 | Requester's allowed ways, bit i = way i; 0 means all |
| lock_req | input | 1 | The fill should lock the new line |
| hint_way | input | 3 | Preferred victim from the replacement-order block |
| res_vld | output | 1 | Selection result valid |
| res_way | output | 3 | Way to fill |
| res_lock_bits | output | 8 | Lock bits to write back at the index |
| refuse_clr | input | 1 | Write-one clear of the refusal flag |
| starve_clr | input | 1 | Write-one clear of the starvation flag |
| refuse_irq_en | input | 1 | Interrupt enable for the refusal flag |
| starve_irq_en | input | 1 | Interrupt enable for the starvation flag |
| refuse_flag | output | 1 | Sticky: a lock request was refused |
| starve_flag | output | 1 | Sticky: a miss found all allowed ways locked |
| lock_irq | output | 1 | Interrupt request |

## Verification
The bench aims at the edges of the free-way count: exactly one allowed unlocked way with a lock request (a design that counts all ways instead of allowed ones would pin the last free way and report nothing), zero free ways with a lock request pending (a wrong design would keep the lock or pick a locked way above the lowest allowed), and an all-zero mask (a literal reading would starve on every miss). It also drives a hint pointing at a locked or disallowed way, which a careless design would accept, and a flag set coinciding with its clear, where a clear-priority design would lose the event. Back-to-back misses check that each result lines up with its own request.

// File: rtl/repl_sel_pkg.sv
package repl_sel_pkg;
  // Error kinds reported by the selector; the value is the flag index.
  localparam int unsigned ERR_KINDS = 2;
  typedef enum logic [0:0] {
    ERR_REFUSE = 1'b0,
    ERR_STARVE = 1'b1
  } err_kind_e;
endpackage

// File: rtl/low_one_find.sv
// Returns the index of the lowest set bit; zero when none is set.
module low_one_find #(
  parameter int unsigned N = 8,
  localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] vec,
  output logic [W-1:0] idx,
  output logic         found
);
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx   = W'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/way_free_scan.sv
// Builds the effective allowed set and the allowed-unlocked set.
module way_free_scan #(
  parameter int unsigned N_WAYS = 8,
  localparam int unsigned WAY_W = (N_WAYS > 1) ? $clog2(N_WAYS) : 1,
  localparam int unsigned CNT_W = $clog2(N_WAYS + 1)
) (
  input  logic [N_WAYS-1:0] lock_vec,
  input  logic [N_WAYS-1:0] part_mask,
  output logic [N_WAYS-1:0] eff_mask,
  output logic [N_WAYS-1:0] free_vec,
  output logic              any_free,
  output logic              single_free,
  output logic [WAY_W-1:0]  low_free,
  output logic [WAY_W-1:0]  low_allowed
);
  logic [CNT_W-1:0] free_cnt;
  logic             unused_found;

  always_comb begin
    eff_mask = (part_mask == '0) ? '1 : part_mask;
    free_vec = eff_mask & ~lock_vec;
  end

  always_comb begin
    free_cnt = '0;
    for (int i = 0; i < N_WAYS; i++) begin
      free_cnt = free_cnt + CNT_W'(free_vec[i]);
    end
    single_free = (free_cnt == CNT_W'(1));
  end

  low_one_find #(.N(N_WAYS)) u_low_free (
    .vec   (free_vec),
    .idx   (low_free),
    .found (any_free)
  );

  low_one_find #(.N(N_WAYS)) u_low_allowed (
    .vec   (eff_mask),
    .idx   (low_allowed),
    .found (unused_found)
  );
endmodule

// File: rtl/way_choose.sv
// Picks the victim and computes the lock bits to write back.
module way_choose #(
  parameter int unsigned N_WAYS = 8,
  localparam int unsigned WAY_W = (N_WAYS > 1) ? $clog2(N_WAYS) : 1
) (
  input  logic [N_WAYS-1:0] lock_vec,
  input  logic [N_WAYS-1:0] free_vec,
  input  logic              any_free,
  input  logic              single_free,
  input  logic [WAY_W-1:0]  low_free,
  input  logic [WAY_W-1:0]  low_allowed,
  input  logic [WAY_W-1:0]  hint,
  input  logic              lock_req,
  output logic [WAY_W-1:0]  pick_way,
  output logic [N_WAYS-1:0] next_lock,
  output logic              refuse_hit,
  output logic              starve_hit
);
  logic hint_ok;

  always_comb begin
    hint_ok = (32'(hint) < N_WAYS) && free_vec[hint];
  end

  always_comb begin
    pick_way   = low_allowed;
    next_lock  = lock_vec;
    refuse_hit = 1'b0;
    starve_hit = 1'b0;
    if (any_free) begin
      pick_way = hint_ok ? hint : low_free;
      if (lock_req) begin
        if (single_free) begin
          refuse_hit = 1'b1;
        end else begin
          next_lock[pick_way] = 1'b1;
        end
      end
    end else begin
      pick_way              = low_allowed;
      next_lock[low_allowed] = 1'b0;
      starve_hit            = 1'b1;
    end
  end
endmodule

// File: rtl/err_flag_bank.sv
// Sticky write-one-to-clear flags with per-flag interrupt enables.
module err_flag_bank #(
  parameter int unsigned N_FLAGS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_FLAGS-1:0] set_i,
  input  logic [N_FLAGS-1:0] clr_i,
  input  logic [N_FLAGS-1:0] en_i,
  output logic [N_FLAGS-1:0] flag_o,
  output logic               irq_o
);
  logic [N_FLAGS-1:0] flag_q;
  logic [N_FLAGS-1:0] flag_d;

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    always_comb begin
      flag_d[g] = set_i[g] | (flag_q[g] & ~clr_i[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[g] <= 1'b0;
      end else if (set_i[g] || clr_i[g]) begin
        flag_q[g] <= flag_d[g];
      end
    end

    assert_sticky_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[g] && !clr_i[g]) |=> flag_q[g]);
    assert_set_wins_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> flag_q[g]);
    assert_clear_only_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !flag_q[g]);
  end

  always_comb begin
    flag_o = flag_q;
    irq_o  = |(flag_q & en_i);
  end
endmodule

// File: rtl/repl_way_sel.sv
module repl_way_sel
  import repl_sel_pkg::*;
#(
  parameter int unsigned N_WAYS = 8,
  localparam int unsigned WAY_W = (N_WAYS > 1) ? $clog2(N_WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_vld,
  input  logic [N_WAYS-1:0] lock_bits_in,
  input  logic [N_WAYS-1:0] part_mask,
  input  logic              lock_req,
  input  logic [WAY_W-1:0]  hint_way,
  output logic              res_vld,
  output logic [WAY_W-1:0]  res_way,
  output logic [N_WAYS-1:0] res_lock_bits,
  input  logic              refuse_clr,
  input  logic              starve_clr,
  input  logic              refuse_irq_en,
  input  logic              starve_irq_en,
  output logic              refuse_flag,
  output logic              starve_flag,
  output logic              lock_irq
);
  logic [N_WAYS-1:0]    eff_mask;
  logic [N_WAYS-1:0]    free_vec;
  logic                 any_free;
  logic                 single_free;
  logic [WAY_W-1:0]     low_free;
  logic [WAY_W-1:0]     low_allowed;
  logic [WAY_W-1:0]     pick_way;
  logic [N_WAYS-1:0]    next_lock;
  logic                 refuse_hit;
  logic                 starve_hit;
  logic [ERR_KINDS-1:0] err_set;
  logic [ERR_KINDS-1:0] err_clr;
  logic [ERR_KINDS-1:0] err_en;
  logic [ERR_KINDS-1:0] err_flag;

  logic              vld_q,  vld_d;
  logic [WAY_W-1:0]  way_q,  way_d;
  logic [N_WAYS-1:0] lock_q, lock_d;

  way_free_scan #(.N_WAYS(N_WAYS)) u_scan (
    .lock_vec    (lock_bits_in),
    .part_mask   (part_mask),
    .eff_mask    (eff_mask),
    .free_vec    (free_vec),
    .any_free    (any_free),
    .single_free (single_free),
    .low_free    (low_free),
    .low_allowed (low_allowed)
  );

  way_choose #(.N_WAYS(N_WAYS)) u_choose (
    .lock_vec    (lock_bits_in),
    .free_vec    (free_vec),
    .any_free    (any_free),
    .single_free (single_free),
    .low_free    (low_free),
    .low_allowed (low_allowed),
    .hint        (hint_way),
    .lock_req    (lock_req),
    .pick_way    (pick_way),
    .next_lock   (next_lock),
    .refuse_hit  (refuse_hit),
    .starve_hit  (starve_hit)
  );

  // Next-state for the result register.
  always_comb begin
    vld_d  = miss_vld;
    way_d  = pick_way;
    lock_d = next_lock;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      way_q  <= '0;
      lock_q <= '0;
    end else if (miss_vld) begin
      way_q  <= way_d;
      lock_q <= lock_d;
    end
  end

  always_comb begin
    err_set[ERR_REFUSE] = miss_vld & refuse_hit;
    err_set[ERR_STARVE] = miss_vld & starve_hit;
    err_clr[ERR_REFUSE] = refuse_clr;
    err_clr[ERR_STARVE] = starve_clr;
    err_en[ERR_REFUSE]  = refuse_irq_en;
    err_en[ERR_STARVE]  = starve_irq_en;
  end

  err_flag_bank #(.N_FLAGS(ERR_KINDS)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (err_set),
    .clr_i  (err_clr),
    .en_i   (err_en),
    .flag_o (err_flag),
    .irq_o  (lock_irq)
  );

  always_comb begin
    res_vld       = vld_q;
    res_way       = way_q;
    res_lock_bits = lock_q;
    refuse_flag   = err_flag[ERR_REFUSE];
    starve_flag   = err_flag[ERR_STARVE];
  end

  // A free allowed way exists: the chooser must land on one of them.
  assert_free_way_chosen_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (miss_vld && any_free) |-> free_vec[pick_way]);
  // Refused lock leaves the index's lock bits untouched.
  assert_refuse_keeps_locks_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    (miss_vld && refuse_hit) |=> (res_lock_bits == $past(lock_bits_in)));
  assert_one_error_kind_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({refuse_hit, starve_hit}));
  // Starvation unpins the way it hands out.
  assert_starve_unlocks_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (miss_vld && !any_free) |=> (!res_lock_bits[res_way] && eff_mask == eff_mask));
  assert_starve_flags_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (miss_vld && !any_free) |=> starve_flag);
  assert_result_follows_R11 : assert property (@(posedge clk) disable iff (!rst_n)
    miss_vld |=> res_vld);
  assert_result_idle_R11 : assert property (@(posedge clk) disable iff (!rst_n)
    !miss_vld |=> (!res_vld && $stable(res_way) && $stable(res_lock_bits)));
endmodule

// File: tb/repl_way_sel_test.sv
`timescale 1ns/1ps
module repl_way_sel_test;
  localparam int N = 8;
  localparam int WW = 3;

  typedef struct packed {
    logic [WW-1:0] way;
    logic [N-1:0]  locks;
    logic          fr;
    logic          fs;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          miss_vld;
  logic [N-1:0]  lock_bits_in;
  logic [N-1:0]  part_mask;
  logic          lock_req;
  logic [WW-1:0] hint_way;
  logic          res_vld;
  logic [WW-1:0] res_way;
  logic [N-1:0]  res_lock_bits;
  logic          refuse_clr, starve_clr, refuse_irq_en, starve_irq_en;
  logic          refuse_flag, starve_flag, lock_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic m_fr = 1'b0;
  logic m_fs = 1'b0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  repl_way_sel uut (
    .clk(clk), .rst_n(rst_n), .miss_vld(miss_vld), .lock_bits_in(lock_bits_in),
    .part_mask(part_mask), .lock_req(lock_req), .hint_way(hint_way),
    .res_vld(res_vld), .res_way(res_way), .res_lock_bits(res_lock_bits),
    .refuse_clr(refuse_clr), .starve_clr(starve_clr),
    .refuse_irq_en(refuse_irq_en), .starve_irq_en(starve_irq_en),
    .refuse_flag(refuse_flag), .starve_flag(starve_flag), .lock_irq(lock_irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Independent reference of the selection rules.
  function automatic exp_t model(input logic [N-1:0] lk, input logic [N-1:0] mk,
                                 input logic rq, input logic [WW-1:0] h);
    exp_t e;
    logic [N-1:0] em, fr;
    int cnt, low;
    em = (mk == 0) ? {N{1'b1}} : mk;
    fr = em & ~lk;
    cnt = 0;
    for (int i = 0; i < N; i++) cnt += fr[i];
    e.locks = lk; e.fr = 0; e.fs = 0;
    if (cnt > 0) begin
      low = -1;
      for (int i = 0; i < N; i++) if (fr[i] && low < 0) low = i;
      e.way = fr[h] ? h : WW'(low);
      if (rq) begin
        if (cnt == 1) e.fr = 1;
        else e.locks[e.way] = 1'b1;
      end
    end else begin
      low = -1;
      for (int i = 0; i < N; i++) if (em[i] && low < 0) low = i;
      e.way = WW'(low);
      e.locks[e.way] = 1'b0;
      e.fs = 1;
    end
    return e;
  endfunction

  task automatic send(input logic [N-1:0] lk, input logic [N-1:0] mk, input logic rq,
                      input logic [WW-1:0] h, input logic cr, input logic cs);
    exp_t e;
    @(negedge clk);
    miss_vld = 1; lock_bits_in = lk; part_mask = mk; lock_req = rq; hint_way = h;
    refuse_clr = cr; starve_clr = cs;
    e = model(lk, mk, rq, h);
    m_fr = e.fr | (m_fr & ~cr);
    m_fs = e.fs | (m_fs & ~cs);
    e.fr = m_fr; e.fs = m_fs;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    miss_vld = 0; lock_req = 0; refuse_clr = 0; starve_clr = 0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compares every result against the oldest queued expectation.
  always @(negedge clk) begin
    if (rst_n && res_vld) begin
      if (sb.size() == 0) begin
        chk(0, "R11 unexpected result", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(res_way == e.way, "R3/R4/R5/R8 way", 32'(res_way), 32'(e.way));
        chk(res_lock_bits == e.locks, "R6/R7/R8 lock bits", 32'(res_lock_bits), 32'(e.locks));
        chk(refuse_flag == e.fr, "R7 refuse flag", 32'(refuse_flag), 32'(e.fr));
        chk(starve_flag == e.fs, "R8 starve flag", 32'(starve_flag), 32'(e.fs));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; miss_vld = 0; lock_bits_in = 0; part_mask = 0; lock_req = 0;
    hint_way = 0; refuse_clr = 0; starve_clr = 0; refuse_irq_en = 1; starve_irq_en = 1;
    repeat (3) @(negedge clk);
    chk(res_vld == 0, "R1 res_vld", res_vld, 0);
    chk(refuse_flag == 0 && starve_flag == 0, "R1 flags", {refuse_flag, starve_flag}, 0);
    chk(lock_irq == 0, "R1 irq", lock_irq, 0);
    rst_n = 1;
    @(negedge clk);

    // R2/R3: zero mask, hint taken
    send(8'h00, 8'h00, 0, 3'd5, 0, 0);
    // R4: hint outside mask
    send(8'h01, 8'h0F, 0, 3'd6, 0, 0);
    // R4/R5: hint locked
    send(8'h10, 8'hFF, 0, 3'd4, 0, 0);
    // R6: lock granted
    send(8'h00, 8'hF0, 1, 3'd7, 0, 0);
    // R7: last free way, lock refused
    send(8'h02, 8'h03, 1, 3'd0, 0, 0);
    // R8: all allowed locked, lock request ignored
    send(8'h3C, 8'h0C, 1, 3'd3, 0, 0);
    // R8 with zero mask, everything locked
    send(8'hFF, 8'h00, 0, 3'd6, 0, 0);
    idle(3);
    chk(sb.size() == 0, "R11 all results seen", sb.size(), 0);
    // R11: idle holds
    chk(res_vld == 0, "R11 res_vld idle", res_vld, 0);
    chk(res_way == 3'd0 && res_lock_bits == 8'hFE, "R11 hold",
        {res_way, res_lock_bits}, {3'd0, 8'hFE});
    chk(refuse_flag && starve_flag, "R9 sticky", {refuse_flag, starve_flag}, 2'b11);

    // R10
    refuse_irq_en = 0; starve_irq_en = 0; #1;
    chk(lock_irq == 0, "R10 disabled", lock_irq, 0);
    refuse_irq_en = 1; #1;
    chk(lock_irq == 1, "R10 refuse enabled", lock_irq, 1);

    // R9: clear refuse only
    @(negedge clk); refuse_clr = 1;
    @(negedge clk); refuse_clr = 0; m_fr = 0;
    chk(refuse_flag == 0 && starve_flag == 1, "R9 clear", {refuse_flag, starve_flag}, 2'b01);
    #1 chk(lock_irq == 0, "R10 flag cleared", lock_irq, 0);
    starve_irq_en = 1; #1;
    chk(lock_irq == 1, "R10 starve enabled", lock_irq, 1);

    // R9: set and clear together keep the flag; starve cleared alone
    send(8'h40, 8'hC0, 1, 3'd7, 1, 1);
    send(8'h00, 8'h00, 1, 3'd2, 0, 0);
    idle(2);
    chk(refuse_flag == 1 && starve_flag == 0, "R9 set wins",
        {refuse_flag, starve_flag}, 2'b10);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule